// File: doc/BRIEF.md
# Multichannel DMA Address Sequencer

This block generates the addresses for a DMA engine with twelve channels and eight memory resources. Each channel has its own start address, address step, transfer count, service interval, target resource, addressing mode and interrupt selection. In circular mode a channel walks a ring buffer over and over. In linear mode it walks the buffer once and then goes quiet. Each resource has its own round-robin arbiter. In every cycle that arbiter grants one of the channels that target it and are ready, and it presents that channel's current address.

Configuration is written per channel into a shadow copy. That copy becomes active only when a disabled channel is enabled. Enabling also restarts the channel at its start address. The grant, channel number and address on each resource are combinational from registered state. The channel's state advances at the clock edge that ends the grant cycle. Six event lines pulse in the same cycle as the grant that closes a pass through a channel's buffer.

Top module: `dma_addrgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no resource shows a grant and no event line is high.
- R2: In circular mode (mode bit 1) a channel issues addresses start, start+step, start+2·step and so on. After the transfer whose count equals the length, it returns to start.
- R3: In linear mode (mode bit 0) a channel issues length addresses that start at start and rise by step each time. After the last one it is never granted again until it is re-enabled.
- R4: After a channel is granted, it is not granted again for the number of cycles in its interval field. With interval 0 it can be granted in every cycle.
- R5: Among the ready channels on one resource, the arbiter grants the first one found in ascending order, wrapping around, starting after the channel it granted last. With several channels always ready, the grants rotate.
- R6: The 3-bit event field picks event line 0 to 5. That line is high during the grant cycle of the transfer that closes a pass: the wrap in circular mode, or the final transfer in linear mode. A field value of 6 or 7 drives no line.
- R7: Each resource arbitrates on its own, so grants on different resources can happen in the same cycle.
- R8: A configuration write to an enabled channel does not change its address sequence. An enable write to a channel that is already enabled does not restart it.
- R9: Enabling a disabled channel loads its shadow configuration and restarts it at the start address with its interval cleared. It is ready in the cycle after the enable write.
- R10: From the cycle after a disable write, the channel is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write the shadow configuration of channel cfg_ch |
| cfg_ch | input | 4 | Channel being configured |
| cfg_start | input | 16 | Start address |
| cfg_step | input | 16 | Address increment per transfer |
| cfg_len | input | 12 | Transfers per pass (0 behaves as 1) |
| cfg_ivl | input | 8 | Idle cycles after each service |
| cfg_res | input | 3 | Target resource |
| cfg_circ | input | 1 | 1 circular, 0 linear |
| cfg_evt | input | 3 | Event line number, 6 or 7 for none |
| en_we | input | 1 | Enable/disable write for channel en_ch |
| en_ch | input | 4 | Channel being enabled or disabled |
| en_val | input | 1 | 1 enable, 0 disable |
| gnt_vld | output | 8 | Per resource: a channel is granted this cycle |
| gnt_ch | output | 32 | Per resource, 4 bits each: granted channel |
| gnt_addr | output | 128 | Per resource, 16 bits each: address of the granted transfer |
| evt | output | 6 | Event pulses |

## Verification
A channel whose address or transfer count has gone wrong shows a wrong value on its resource's address lines at its next grant. A fault in the count shows up as an event pulse in the wrong cycle and, in linear mode, as a missing grant or one grant too many. A faulty interval counter or arbitration pointer moves grants into other cycles or breaks the rotation, and this shows within one interval or one round of the ready channels. A channel that still holds stale state after a disable or enable shows it at the first grant after the enable.

// File: rtl/dma_addrgen.sv
module dma_addrgen #(
  parameter int NCH  = 12,
  parameter int NRES = 8,
  parameter int NEV  = 6,
  parameter int AW   = 16,
  parameter int LW   = 12,
  parameter int TW   = 8,
  localparam int CW  = $clog2(NCH),
  localparam int RW  = $clog2(NRES),
  localparam int EW  = $clog2(NEV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CW-1:0]      cfg_ch,
  input  logic [AW-1:0]      cfg_start,
  input  logic [AW-1:0]      cfg_step,
  input  logic [LW-1:0]      cfg_len,
  input  logic [TW-1:0]      cfg_ivl,
  input  logic [RW-1:0]      cfg_res,
  input  logic               cfg_circ,
  input  logic [EW-1:0]      cfg_evt,
  input  logic               en_we,
  input  logic [CW-1:0]      en_ch,
  input  logic               en_val,
  output logic [NRES-1:0]    gnt_vld,
  output logic [NRES*CW-1:0] gnt_ch,
  output logic [NRES*AW-1:0] gnt_addr,
  output logic [NEV-1:0]     evt
);

  logic [NCH-1:0][AW-1:0] sh_start, sh_step, a_start, a_step, addr;
  logic [NCH-1:0][LW-1:0] sh_len, a_len, idx;
  logic [NCH-1:0][TW-1:0] sh_ivl, a_ivl, cnt;
  logic [NCH-1:0][RW-1:0] sh_res, a_res;
  logic [NCH-1:0][EW-1:0] sh_evt, a_evt;
  logic [NCH-1:0]         sh_circ, a_circ, en, done, req, served, pass_end;
  logic [NRES-1:0][CW-1:0] last, sel;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign req[c]      = en[c] & ~done[c] & (cnt[c] == '0);
    assign served[c]   = gnt_vld[a_res[c]] & (sel[a_res[c]] == CW'(c));
    assign pass_end[c] = ({1'b0, idx[c]} + 1'b1) >= {1'b0, a_len[c]};
  end

  for (genvar r = 0; r < NRES; r++) begin : g_res
    always_comb begin
      gnt_vld[r] = 1'b0;
      sel[r]     = '0;
      for (int k = 1; k <= NCH; k++) begin
        int c;
        c = (int'(last[r]) + k) % NCH;
        if (!gnt_vld[r] && req[c] && a_res[c] == RW'(r)) begin
          gnt_vld[r] = 1'b1;
          sel[r]     = CW'(c);
        end
      end
    end
    assign gnt_ch[r*CW +: CW]   = sel[r];
    assign gnt_addr[r*AW +: AW] = addr[sel[r]];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          last[r] <= CW'(NCH - 1);
      else if (gnt_vld[r]) last[r] <= sel[r];
  end

  always_comb begin
    evt = '0;
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NEV; e++)
        if (served[c] && pass_end[c] && a_evt[c] == EW'(e)) evt[e] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sh_start, sh_step, sh_len, sh_ivl, sh_res, sh_circ, sh_evt} <= '0;
      {a_start, a_step, a_len, a_ivl, a_res, a_circ, a_evt} <= '0;
      {addr, idx, cnt, en, done} <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (cfg_we && cfg_ch == CW'(c)) begin
          sh_start[c] <= cfg_start;
          sh_step[c]  <= cfg_step;
          sh_len[c]   <= cfg_len;
          sh_ivl[c]   <= cfg_ivl;
          sh_res[c]   <= cfg_res;
          sh_circ[c]  <= cfg_circ;
          sh_evt[c]   <= cfg_evt;
        end
        if (en_we && en_ch == CW'(c) && !en_val) begin
          en[c] <= 1'b0;
        end else if (en_we && en_ch == CW'(c) && !en[c]) begin
          en[c]      <= 1'b1;
          a_start[c] <= sh_start[c];
          a_step[c]  <= sh_step[c];
          a_len[c]   <= sh_len[c];
          a_ivl[c]   <= sh_ivl[c];
          a_res[c]   <= sh_res[c];
          a_circ[c]  <= sh_circ[c];
          a_evt[c]   <= sh_evt[c];
          addr[c]    <= sh_start[c];
          idx[c]     <= '0;
          cnt[c]     <= '0;
          done[c]    <= 1'b0;
        end else if (served[c]) begin
          cnt[c] <= a_ivl[c];
          if (pass_end[c] && a_circ[c]) begin
            addr[c] <= a_start[c];
            idx[c]  <= '0;
          end else begin
            addr[c] <= addr[c] + a_step[c];
            idx[c]  <= idx[c] + 1'b1;
            if (pass_end[c]) done[c] <= 1'b1;
          end
        end else if (en[c] && cnt[c] != '0) begin
          cnt[c] <= cnt[c] - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dma_addrgen_chk.sv
module dma_addrgen_chk #(
  parameter int NCH  = 12,
  parameter int NRES = 8,
  parameter int NEV  = 6,
  parameter int TW   = 8,
  localparam int CW  = $clog2(NCH),
  localparam int RW  = $clog2(NRES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0][RW-1:0] a_res,
  input logic [NCH-1:0][TW-1:0] a_ivl,
  input logic [NRES-1:0]        gnt_vld,
  input logic [NRES*CW-1:0]     gnt_ch,
  input logic [NEV-1:0]         evt
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (gnt_vld == '0 && evt == '0));

  assert_event_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |-> (gnt_vld != '0));

  for (genvar r = 0; r < NRES; r++) begin : g_r
    assert_grant_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[r] |-> en[gnt_ch[r*CW +: CW]]);

    assert_grant_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[r] |-> (a_res[gnt_ch[r*CW +: CW]] == RW'(r)));

    assert_interval_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld[r] && a_ivl[gnt_ch[r*CW +: CW]] != '0)
      |=> !(gnt_vld[r] && gnt_ch[r*CW +: CW] == $past(gnt_ch[r*CW +: CW])));
  end

endmodule

bind dma_addrgen dma_addrgen_chk #(.NCH(NCH), .NRES(NRES), .NEV(NEV), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .a_res(a_res), .a_ivl(a_ivl),
  .gnt_vld(gnt_vld), .gnt_ch(gnt_ch), .evt(evt)
);

// File: tb/sim_dma_addrgen.sv
module sim_dma_addrgen;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, en_we = 0, en_val = 0, cfg_circ = 0;
  logic [3:0] cfg_ch = 0, en_ch = 0;
  logic [15:0] cfg_start = 0, cfg_step = 0;
  logic [11:0] cfg_len = 0;
  logic [7:0] cfg_ivl = 0;
  logic [2:0] cfg_res = 0, cfg_evt = 0;
  logic [7:0] gnt_vld;
  logic [31:0] gnt_ch;
  logic [127:0] gnt_addr;
  logic [5:0] evt;
  int checks = 0, errors = 0;

  dma_addrgen u0 (.*);

  always #5 clk = ~clk;

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int ga(int r); return int'(gnt_addr[r*16 +: 16]); endfunction
  function automatic int gc(int r); return int'(gnt_ch[r*4 +: 4]); endfunction

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(int ch, int st, int sp, int ln, int iv, int rs, bit circ, int ev);
    cfg_ch = 4'(ch); cfg_start = 16'(st); cfg_step = 16'(sp); cfg_len = 12'(ln);
    cfg_ivl = 8'(iv); cfg_res = 3'(rs); cfg_circ = circ; cfg_evt = 3'(ev);
    cfg_we = 1; tick; cfg_we = 0;
  endtask

  task automatic enable(int ch, bit v);
    en_ch = 4'(ch); en_val = v; en_we = 1; tick; en_we = 0;
  endtask

  task automatic t_reset;
    tick; tick;
    chk("R1 grants in reset", int'(gnt_vld), 0);
    chk("R1 events in reset", int'(evt), 0);
    rst_n = 1; tick;
    chk("R1 grants after reset", int'(gnt_vld), 0);
  endtask

  task automatic t_circular;
    cfg(5, 100, 4, 3, 0, 2, 1, 2);
    enable(5, 1);
    for (int k = 0; k < 7; k++) begin
      chk("R2 grant", int'(gnt_vld[2]), 1);
      chk("R2 channel", gc(2), 5);
      chk("R2 address", ga(2), 100 + 4 * (k % 3));
      chk("R6 wrap event", int'(evt), (k % 3 == 2) ? 6'b000100 : 0);
      tick;
    end
    enable(5, 0);
    chk("R10 no grant after disable", int'(gnt_vld[2]), 0);
  endtask

  task automatic t_linear;
    cfg(1, 200, 2, 2, 0, 3, 0, 4);
    enable(1, 1);
    chk("R3 first address", ga(3), 200);
    chk("R6 no event mid pass", int'(evt), 0);
    tick;
    chk("R3 second address", ga(3), 202);
    chk("R6 completion event", int'(evt), 6'b010000);
    tick;
    for (int k = 0; k < 3; k++) begin
      chk("R3 stopped", int'(gnt_vld[3]), 0);
      tick;
    end
    enable(1, 0);
  endtask

  task automatic t_interval;
    cfg(2, 0, 1, 100, 3, 4, 1, 7);
    enable(2, 1);
    for (int k = 0; k < 9; k++) begin
      chk("R4 grant spacing", int'(gnt_vld[4]), (k % 4 == 0) ? 1 : 0);
      if (k % 4 == 0) chk("R4 address", ga(4), k / 4);
      chk("R6 field 7 silent", int'(evt), 0);
      tick;
    end
    enable(2, 0);
  endtask

  task automatic t_round_robin;
    int prev, cur;
    cfg(0, 0, 1, 4000, 0, 0, 0, 6);
    cfg(1, 1000, 1, 4000, 0, 0, 0, 6);
    cfg(2, 2000, 1, 4000, 0, 0, 0, 6);
    cfg(11, 3000, 1, 4000, 0, 1, 0, 6);
    enable(0, 1); enable(1, 1); enable(2, 1); enable(11, 1);
    prev = gc(0);
    tick;
    for (int k = 1; k < 6; k++) begin
      cur = gc(0);
      chk("R5 rotation", cur, (prev + 1) % 3);
      chk("R7 parallel grant", int'(gnt_vld[1]), 1);
      chk("R7 parallel channel", gc(1), 11);
      chk("R6 field 6 silent", int'(evt), 0);
      prev = cur;
      tick;
    end
    enable(0, 0); enable(1, 0); enable(2, 0); enable(11, 0);
    chk("R10 all idle", int'(gnt_vld), 0);
  endtask

  task automatic t_locked;
    cfg(6, 500, 1, 10, 0, 5, 1, 7);
    enable(6, 1);
    chk("R9 start address", ga(5), 500);
    tick;
    chk("R2 next address", ga(5), 501);
    cfg(6, 900, 1, 10, 0, 5, 1, 7);
    chk("R8 write while enabled ignored", ga(5), 502);
    enable(6, 1);
    chk("R8 re-enable no restart", ga(5), 503);
    enable(6, 0);
    chk("R10 disabled", int'(gnt_vld[5]), 0);
    tick;
    chk("R10 stays disabled", int'(gnt_vld[5]), 0);
    enable(6, 1);
    chk("R9 new start after re-enable", ga(5), 900);
    enable(6, 0);
  endtask

  initial begin
    t_reset;
    t_circular;
    t_linear;
    t_interval;
    t_round_robin;
    t_locked;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule